// File: doc/BRIEF.md
# Bus-Mapped Serial Port Register Front End

This block is the register side of a simple serial port, seen by a processor through an APB slave port. A five-word window holds a data port, a status word, a control word and two placeholder words. Bytes arriving on a valid/ready byte-stream input are kept in a small receive store. The processor drains that store one byte per data-port read. Data-port writes leave the block on a byte output with a one-cycle valid strobe. Receive and transmit are each gated by their own control bit. A single interrupt line gives one-cycle pulses on receive and transmit events, and each of the two sources has its own enable.

The receive store is not circular. Its fill level only grows until every buffered byte has been read. At that point the read index and the fill level both drop back to zero together. Space therefore comes back only once the store is fully drained. Bit-rate generation, the serial shifter, parity, flow control and loopback sit outside this block.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000_0006 (bit 1 and bit 2 set), `rx_ready` is high, and `irq` and `tx_valid` are low.
- R2: A byte offered while `rx_valid` and `rx_ready` are both high is stored only when control bit 0 (receive enable) is set. Storing a byte sets status bit 0 (data ready). When receive enable is clear, the byte is dropped and the status word does not change.
- R3: When a byte is stored and control bit 2 is set, `irq` is high for exactly the one cycle that follows the storing edge.
- R4: An APB write to the data port (offset 0x00) with control bit 1 set drives `tx_valid` high for the next cycle, with `tx_data` equal to `pwdata[7:0]`. With control bit 1 clear, `tx_valid` stays low.
- R5: When a byte is sent and control bit 3 is set, `irq` is high for the one cycle in which `tx_valid` is high.
- R6: An APB read of the data port returns the oldest stored byte in bits 7:0 and removes exactly that one byte. Reading the last byte empties the store and clears status bit 0. A read of an empty store returns 0.
- R7: Offset 0x03 behaves exactly like offset 0x00 for both reads and writes.
- R8: The control word at offset 0x08 reads back all 32 written bits. Writes to the status word at offset 0x04 have no effect.
- R9: The word at offset 0x0C, the word at offset 0x10 and any other unused offset read as 0, and writes to them have no effect.
- R10: Once DEPTH bytes have been stored without the store being fully drained, `rx_ready` is low and status bit 10 is set. Both stay that way after partial reads and clear only once every byte has been read.
- R11: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte is present |
| rx_ready | output | 1 | Receive store can take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | One-cycle strobe for `tx_data` |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets the non-circular fill. It partly drains a full store and expects `rx_ready` to stay low. A design that recycled space on every read would raise it early. The bench also reads an empty store through both alias offsets and expects zero. A data read must remove exactly one byte, so a design that popped in the setup phase as well would skip bytes and fail the ordering checks. Random phases mix enable patterns with pushes, reads and writes, and those expose interrupt pulses that are missing or stretched, and transmit or receive that leaks past a cleared enable bit.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  // Register offsets inside the window (byte addresses)
  localparam int unsigned OFS_DATA   = 32'h00;
  localparam int unsigned OFS_DATA_B = 32'h03;
  localparam int unsigned OFS_STAT   = 32'h04;
  localparam int unsigned OFS_CTRL   = 32'h08;
  localparam int unsigned OFS_SCAL   = 32'h0C;
  localparam int unsigned OFS_DBG    = 32'h10;

  // Control bit positions
  localparam int CB_RX_ON  = 0;
  localparam int CB_TX_ON  = 1;
  localparam int CB_RX_IRQ = 2;
  localparam int CB_TX_IRQ = 3;

  // Status bit positions
  localparam int SB_HAVE_BYTE = 0;
  localparam int SB_SHIFT_IDL = 1;
  localparam int SB_TXQ_IDLE  = 2;
  localparam int SB_RXQ_FULL  = 10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCAL,
    SEL_DBG
  } reg_sel_e;

endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] fill_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] rd_q, rd_n;
  logic [CW-1:0] fill_q, fill_n;
  logic          pop_eff;
  logic          drain_last;
  logic [IW-1:0] wr_idx;

  assign empty_o = (rd_q == IW'(0)) && (fill_q == CW'(0));
  assign full_o  = (fill_q == CW'(DEPTH));
  assign fill_o  = fill_q;

  assign pop_eff    = pop_i && (fill_q != CW'(0));
  assign drain_last = pop_eff && ((CW'(rd_q) + CW'(1)) == fill_q);
  assign wr_idx     = drain_last ? IW'(0) : IW'(fill_q);

  always_comb begin
    rd_n   = rd_q;
    fill_n = fill_q;
    if (drain_last) begin
      rd_n   = IW'(0);
      fill_n = push_i ? CW'(1) : CW'(0);
    end else begin
      if (pop_eff) rd_n = rd_q + IW'(1);
      if (push_i)  fill_n = fill_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      rd_q   <= rd_n;
      fill_q <= fill_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_idx] <= din_i;
  end

  assign dout_o = (fill_q == CW'(0)) ? '0 : mem_q[rd_q];

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_last && !push_i) |=> (fill_q == CW'(0) && rd_q == IW'(0))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH)); // R10
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> full_o); // R10

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data_i,
  input  logic [DW-1:0] byte_i,
  input  logic          tx_on_i,
  input  logic          tx_irq_on_i,
  input  logic          rx_stored_i,
  input  logic          rx_irq_on_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o
);

  logic          send;
  logic          valid_n, irq_n;
  logic [DW-1:0] data_q;
  logic          valid_q, irq_q;

  assign send    = wr_data_i && tx_on_i;
  assign valid_n = send;
  assign irq_n   = (send && tx_irq_on_i) || (rx_stored_i && rx_irq_on_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      irq_q   <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (send) data_q <= byte_i;
  end

  assign tx_valid_o = valid_q;
  assign tx_data_o  = data_q;
  assign irq_o      = irq_q;

  AST_TX_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && tx_on_i) |=> (tx_valid_o && tx_data_o == $past(byte_i))); // R4
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tx_irq_on_i || rx_irq_on_i)); // R5

endmodule

// File: rtl/apb_uart_regs.sv
module apb_uart_regs
  import uart_regs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5,
  localparam int DW    = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  output logic              irq
);

  reg_sel_e      sel;
  logic          access;
  logic          wr_ctrl, wr_data, rd_data;
  logic [31:0]   ctrl_q, ctrl_n;
  logic [31:0]   status;
  logic          rx_store;
  logic [DW-1:0] head;
  logic [CW-1:0] fill;
  logic          full, empty;

  always_comb begin
    unique case (int'(paddr))
      OFS_DATA, OFS_DATA_B: sel = SEL_DATA;
      OFS_STAT:             sel = SEL_STAT;
      OFS_CTRL:             sel = SEL_CTRL;
      OFS_SCAL:             sel = SEL_SCAL;
      OFS_DBG:              sel = SEL_DBG;
      default:              sel = SEL_NONE;
    endcase
  end

  assign access  = psel && penable;
  assign wr_ctrl = access && pwrite && (sel == SEL_CTRL);
  assign wr_data = access && pwrite && (sel == SEL_DATA);
  assign rd_data = access && !pwrite && (sel == SEL_DATA);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // control word
  assign ctrl_n = wr_ctrl ? pwdata : ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  assign rx_ready = !full;
  assign rx_store = rx_valid && rx_ready && ctrl_q[CB_RX_ON];

  uart_rx_store #(.DEPTH(DEPTH), .DW(DW)) i_rx_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_store),
    .din_i   (rx_data),
    .pop_i   (rd_data),
    .dout_o  (head),
    .fill_o  (fill),
    .full_o  (full),
    .empty_o (empty)
  );

  uart_tx_irq #(.DW(DW)) i_tx_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_i   (wr_data),
    .byte_i      (pwdata[DW-1:0]),
    .tx_on_i     (ctrl_q[CB_TX_ON]),
    .tx_irq_on_i (ctrl_q[CB_TX_IRQ]),
    .rx_stored_i (rx_store),
    .rx_irq_on_i (ctrl_q[CB_RX_IRQ]),
    .tx_valid_o  (tx_valid),
    .tx_data_o   (tx_data),
    .irq_o       (irq)
  );

  always_comb begin
    status               = '0;
    status[SB_HAVE_BYTE] = !empty;
    status[SB_SHIFT_IDL] = 1'b1;
    status[SB_TXQ_IDLE]  = 1'b1;
    status[SB_RXQ_FULL]  = full;
  end

  always_comb begin
    prdata = '0;
    unique case (sel)
      SEL_DATA: prdata = {{(32-DW){1'b0}}, head};
      SEL_STAT: prdata = status;
      SEL_CTRL: prdata = ctrl_q;
      default:  prdata = '0;
    endcase
  end

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctrl_q[CB_RX_ON] && !rd_data) |=> (fill == $past(fill))); // R2
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(ctrl_q[CB_TX_ON])); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q)); // R8

endmodule

// File: tb/test_apb_uart_regs.sv
module test_apb_uart_regs;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic [7:0]  rx_data, tx_data;
  logic        rx_valid, rx_ready, tx_valid, irq;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  // bench model
  logic [7:0]  mq[$];
  int          mfill = 0;
  logic [31:0] mctrl = 0;

  // captured after an access or push
  logic        irq_s, txv_s, rdy_s;
  logic [7:0]  txd_s;

  always #5 clk = ~clk;

  apb_uart_regs #(.DEPTH(DEPTH), .ADDR_W(5)) i_apb_uart_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'h6;
    s[0]  = (mq.size() != 0);
    s[10] = (mfill == DEPTH);
    return s;
  endfunction

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    irq_s = irq; txv_s = tx_valid; txd_s = tx_data;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    chk("R11 pready", {31'b0, pready}, 32'h1);
    chk("R11 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge clk);
    psel = 0; penable = 0;
    irq_s = irq; txv_s = tx_valid;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rdy_s = rx_ready;
    @(negedge clk);
    rx_valid = 0;
    irq_s = irq;
    if (rdy_s && mctrl[0]) begin
      mq.push_back(b);
      mfill++;
    end
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    apb_wr(5'h08, v);
    mctrl = v;
  endtask

  task automatic pop_chk(input logic [4:0] a, input string req);
    logic [31:0] d;
    logic [31:0] e;
    e = (mq.size() != 0) ? {24'b0, mq[0]} : 32'h0;
    apb_rd(a, d);
    chk(req, d, e);
    if (mq.size() != 0) void'(mq.pop_front());
    if (mq.size() == 0) mfill = 0;
  endtask

  task automatic stat_chk(input string req);
    logic [31:0] d;
    apb_rd(5'h04, d);
    chk(req, d, exp_status());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'h5eed1);
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    rx_valid = 0; rx_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    #1;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    apb_rd(5'h08, d); chk("R1 control", d, 0);
    apb_rd(5'h04, d); chk("R1 status", d, 32'h6);

    // R6/R7 empty reads return zero
    pop_chk(5'h00, "R6 empty read");
    pop_chk(5'h03, "R7 empty read at alias");

    // R2 receive disabled: dropped
    push(8'hA5);
    chk("R2 no irq when disabled", {31'b0, irq_s}, 0);
    stat_chk("R2 status unchanged when disabled");

    // R3 receive interrupt pulse
    set_ctrl(32'h5);
    push(8'h11);
    chk("R3 irq pulse", {31'b0, irq_s}, 1);
    @(negedge clk);
    chk("R3 irq one cycle", {31'b0, irq}, 0);
    push(8'h22); push(8'h33);
    stat_chk("R2 data ready set");
    pop_chk(5'h00, "R6 order first");
    pop_chk(5'h03, "R7 pop at alias");
    pop_chk(5'h00, "R6 last byte");
    stat_chk("R6 data ready cleared");

    // R10 non-circular full
    set_ctrl(32'h1);
    for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h40));
    chk("R10 ready low when full", {31'b0, rx_ready}, 0);
    stat_chk("R10 full flag");
    push(8'hEE);
    chk("R10 no store when full", {31'b0, rdy_s}, 0);
    pop_chk(5'h00, "R10 partial drain");
    #1 chk("R10 ready stays low after partial drain", {31'b0, rx_ready}, 0);
    stat_chk("R10 full flag held");
    while (mq.size() != 0) pop_chk(5'h00, "R6 drain order");
    #1 chk("R10 ready back after drain", {31'b0, rx_ready}, 1);
    stat_chk("R10 full flag clear");

    // R4 transmit gating
    set_ctrl(32'h0);
    apb_wr(5'h00, 32'h1234_5678);
    chk("R4 no send when disabled", {31'b0, txv_s}, 0);
    set_ctrl(32'hA);
    apb_wr(5'h00, 32'hFFFF_FF9C);
    chk("R4 tx_valid", {31'b0, txv_s}, 1);
    chk("R4 tx_data", {24'b0, txd_s}, 32'h9C);
    chk("R5 tx irq", {31'b0, irq_s}, 1);
    @(negedge clk);
    chk("R4 tx_valid one cycle", {31'b0, tx_valid}, 0);
    apb_wr(5'h03, 32'h0000_0042);
    chk("R7 send at alias", {24'b0, txd_s}, 32'h42);

    // R8 status read-only, control full width
    apb_wr(5'h04, 32'hFFFF_FFFF);
    stat_chk("R8 status write ignored");
    set_ctrl(32'h8765_4321);
    apb_rd(5'h08, d); chk("R8 control readback", d, 32'h8765_4321);

    // R9 placeholders
    apb_wr(5'h0C, 32'hDEAD_BEEF); apb_rd(5'h0C, d); chk("R9 scaler reads 0", d, 0);
    apb_wr(5'h10, 32'hDEAD_BEEF); apb_rd(5'h10, d); chk("R9 debug reads 0", d, 0);
    apb_wr(5'h14, 32'hDEAD_BEEF); apb_rd(5'h14, d); chk("R9 unused reads 0", d, 0);
    apb_rd(5'h08, d); chk("R9 control untouched", d, 32'h8765_4321);

    // random phase
    set_ctrl(32'h0);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        push(8'($urandom));
        chk("R3 irq after push", {31'b0, irq_s}, {31'b0, rdy_s && mctrl[0] && mctrl[2]});
      end else if (op < 7) begin
        pop_chk($urandom_range(0, 1) ? 5'h03 : 5'h00, "R6 random pop");
        stat_chk("R2 random status");
      end else if (op == 7) begin
        set_ctrl({$urandom_range(0, 65535), 12'h0, 4'($urandom)});
      end else begin
        logic [31:0] v;
        v = $urandom;
        apb_wr($urandom_range(0, 1) ? 5'h03 : 5'h00, v);
        chk("R4 random tx_valid", {31'b0, txv_s}, {31'b0, mctrl[1]});
        if (mctrl[1]) chk("R4 random tx_data", {24'b0, txd_s}, {24'b0, v[7:0]});
        chk("R5 random irq", {31'b0, irq_s}, {31'b0, mctrl[1] && mctrl[3]});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule